// File: doc/BRIEF.md
# Strobed Serial Memory Read Controller

This block is the host side of a serial memory that is reached through three active-low strobes (chip enable, output enable, write enable) and a single bidirectional data line. Every serial bit is a complete bus cycle. Each cycle has a setup interval with all strobes high, then a strobe-low interval, then a recovery interval. A write bit is presented on the data line and captured by the memory when the strobes return high. A read bit is driven by the memory while output enable and chip enable are both low.

A client issues a request with a 16-bit start address and a length field. The length field holds the byte count minus one. The controller first opens the memory with a read / write-0 / read cycle triple. It then shifts out the address as 16 write cycles, most significant bit first. It collects each byte with 8 read cycles, most significant bit first, and never resends the address: the memory advances and wraps its own pointer. After the last byte it closes with another read / write-0 / read triple, which ends the sequential read. Assembled bytes leave on a valid/ready stream with a last flag.

Back-pressure rules for the byte stream are as follows. A beat stays valid, with its data and last flag unchanged, until it is accepted by valid and ready both high on a clock edge. The controller may collect the next byte while a beat is waiting. When a further byte is complete and the output is still occupied, no new bus cycle starts, and chip enable stays high until the beat is taken. The memory has no minimum cycle rate, so this pause is harmless. The request side accepts one request when valid and ready are both high, and ready stays low until the transaction is over.

Top module: `strobe_mem_reader`

## Requirements
- R1: Each transaction opens with three bus cycles in this order: a read cycle, a write cycle carrying data 0, and a read cycle.
- R2: The next 16 bus cycles are write cycles carrying req_addr, bit 15 first and bit 0 last, with no read cycle among them.
- R3: Each requested byte is then collected by exactly 8 read cycles (oe_n and ce_n low, we_n high). The first bit read is bit 7 of the byte. No address cycles occur between bytes, so a transaction of N bytes has exactly 22 + 8·N bus cycles.
- R4: mem_we_n and mem_oe_n are never low together, and neither of them is low while mem_ce_n is high.
- R5: mem_io_oe is high whenever mem_we_n is low, and low whenever mem_oe_n is low. After reset, mem_io_oe is low and all three strobes are high.
- R6: In every bus cycle, mem_ce_n is low for exactly LOW_CLKS clocks. Between two cycles, mem_ce_n is high for at least SETUP_CLKS + REC_CLKS clocks.
- R7: A transaction delivers req_len + 1 beats, holding the bytes at addresses (req_addr[8:0] + k) mod 512 in order. rd_last is high on the final beat only. A beat held under back-pressure keeps rd_valid, rd_data and rd_last stable.
- R8: While a completed byte is waiting behind an unaccepted beat, no bus cycle starts. With rd_ready held low in a transaction of two or more bytes, the bus stops after exactly 35 cycles.
- R9: After the final byte, the transaction closes with a read cycle, a write cycle carrying 0, and a read cycle. Only then does req_ready return high.
- R10: req_ready is high after reset and when idle. It drops in the clock after a request is accepted and stays low for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_addr | input | 16 | Start address sent to the memory |
| req_len | input | LEN_W | Number of bytes minus one |
| rd_valid | output | 1 | Byte beat available |
| rd_ready | input | 1 | Consumer accepts the beat |
| rd_data | output | 8 | Assembled byte |
| rd_last | output | 1 | Beat is the final byte of the transaction |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_io_o | output | 1 | Data line value when driven |
| mem_io_oe | output | 1 | Data line output enable |
| mem_io_i | input | 1 | Data line value seen from the memory |

## Verification
The strobe relations are checked on every clock: write enable and output enable never overlap, no strobe is low without chip enable, and the data line is driven in write cycles only. Held beats are also checked on every clock to stay stable, and req_ready is checked to drop after an accepted request. The order and content of the cycles can only be shown by the bench's scenarios: the opening and closing triples, the most-significant-first address, the byte values read through a modelled memory (including the wrap from 0x1FF to 0x000), the strobe-low widths and gaps, and the halt of the bus under back-pressure.

// File: rtl/smr_pkg.sv
package smr_pkg;

  localparam int ADDR_BITS  = 16;
  localparam int BYTE_BITS  = 8;
  localparam int FRAME_CYCS = 3;

  typedef enum logic {
    CYC_RD = 1'b0,
    CYC_WR = 1'b1
  } cyc_kind_e;

  typedef enum logic [1:0] {
    BP_IDLE,
    BP_SETUP,
    BP_LOW,
    BP_REC
  } bus_ph_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_OPEN,
    SQ_ADDR,
    SQ_DATA,
    SQ_PUSH,
    SQ_CLOSE
  } seq_st_e;

endpackage

// File: rtl/smr_cycle_engine.sv
module smr_cycle_engine
  import smr_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int LOW_CLKS   = 3,
  parameter int REC_CLKS   = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  cyc_kind_e kind_i,
  input  logic      wbit_i,
  output logic      ready_o,
  output logic      done_o,
  output logic      rbit_o,
  output logic      ce_n_o,
  output logic      oe_n_o,
  output logic      we_n_o,
  output logic      io_o,
  output logic      io_oe_o,
  input  logic      io_i
);

  localparam int MAXC_A = (SETUP_CLKS > LOW_CLKS) ? SETUP_CLKS : LOW_CLKS;
  localparam int MAXC   = (MAXC_A > REC_CLKS) ? MAXC_A : REC_CLKS;
  localparam int CW     = $clog2(MAXC + 1);

  bus_ph_e   ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_e kind_q, kind_d;
  logic      wbit_q;
  logic      rbit_q;
  logic      ce_n_q, oe_n_q, we_n_q, io_oe_q;
  logic      cnt_end;

  assign cnt_end = (cnt_q == '0);
  assign kind_d  = (start_i && ph_q == BP_IDLE) ? kind_i : kind_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    case (ph_q)
      BP_IDLE: begin
        if (start_i) begin
          ph_d  = BP_SETUP;
          cnt_d = CW'(SETUP_CLKS - 1);
        end
      end
      BP_SETUP: begin
        if (cnt_end) begin
          ph_d  = BP_LOW;
          cnt_d = CW'(LOW_CLKS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BP_LOW: begin
        if (cnt_end) begin
          ph_d  = BP_REC;
          cnt_d = CW'(REC_CLKS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_end) begin
          ph_d   = BP_IDLE;
          done_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= BP_IDLE;
      cnt_q   <= '0;
      kind_q  <= CYC_RD;
      wbit_q  <= 1'b0;
      rbit_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      io_oe_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      if (start_i && ph_q == BP_IDLE) wbit_q <= wbit_i;
      if (ph_q == BP_LOW && cnt_end && kind_q == CYC_RD) rbit_q <= io_i;
      ce_n_q  <= !(ph_d == BP_LOW);
      oe_n_q  <= !(ph_d == BP_LOW && kind_d == CYC_RD);
      we_n_q  <= !(ph_d == BP_LOW && kind_d == CYC_WR);
      io_oe_q <= (ph_d != BP_IDLE) && (kind_d == CYC_WR);
    end
  end

  assign ready_o = (ph_q == BP_IDLE);
  assign rbit_o  = rbit_q;
  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign io_o    = wbit_q;
  assign io_oe_o = io_oe_q;

  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !oe_n_q)); // R4
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_q || !oe_n_q) |-> !ce_n_q); // R4
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> io_oe_q); // R5
  AST_RELEASE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !io_oe_q); // R5
  AST_LOW_HOLDS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_q && $past(!ce_n_q)) |-> ($stable(we_n_q) && $stable(oe_n_q))); // R6

endmodule

// File: rtl/smr_seq_ctrl.sv
module smr_seq_ctrl
  import smr_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [ADDR_BITS-1:0] req_addr_i,
  input  logic [LEN_W-1:0]     req_len_i,
  input  logic                 eng_ready_i,
  input  logic                 eng_done_i,
  input  logic                 eng_rbit_i,
  output logic                 eng_start_o,
  output cyc_kind_e            eng_kind_o,
  output logic                 eng_wbit_o,
  input  logic                 out_free_i,
  output logic                 push_o,
  output logic [BYTE_BITS-1:0] push_data_o,
  output logic                 push_last_o
);

  localparam int SW = $clog2(ADDR_BITS);
  localparam logic [SW-1:0] FRAME_END = SW'(FRAME_CYCS - 1);
  localparam logic [SW-1:0] ADDR_END  = SW'(ADDR_BITS - 1);
  localparam logic [SW-1:0] BYTE_END  = SW'(BYTE_BITS - 1);

  seq_st_e                st_q;
  logic [SW-1:0]          stp_q;
  logic                   pend_q;
  logic [ADDR_BITS-1:0]   addr_q;
  logic [LEN_W-1:0]       left_q;
  logic [BYTE_BITS-1:0]   sh_q;
  logic                   bus_phase;
  logic                   accept;

  assign accept    = (st_q == SQ_IDLE) && req_valid_i;
  assign bus_phase = (st_q == SQ_OPEN) || (st_q == SQ_ADDR) ||
                     (st_q == SQ_DATA) || (st_q == SQ_CLOSE);

  always_comb begin
    eng_kind_o = CYC_RD;
    eng_wbit_o = 1'b0;
    case (st_q)
      SQ_OPEN, SQ_CLOSE: eng_kind_o = (stp_q == SW'(1)) ? CYC_WR : CYC_RD;
      SQ_ADDR: begin
        eng_kind_o = CYC_WR;
        eng_wbit_o = addr_q[~stp_q];
      end
      default: eng_kind_o = CYC_RD;
    endcase
  end

  assign eng_start_o = bus_phase && !pend_q && eng_ready_i;
  assign push_o      = (st_q == SQ_PUSH) && out_free_i;
  assign push_data_o = sh_q;
  assign push_last_o = (left_q == '0);
  assign req_ready_o = (st_q == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      stp_q  <= '0;
      pend_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      sh_q   <= '0;
    end else begin
      if (eng_start_o) pend_q <= 1'b1;
      if (accept) begin
        st_q   <= SQ_OPEN;
        stp_q  <= '0;
        addr_q <= req_addr_i;
        left_q <= req_len_i;
      end
      if (push_o) begin
        stp_q <= '0;
        if (left_q == '0) begin
          st_q <= SQ_CLOSE;
        end else begin
          st_q   <= SQ_DATA;
          left_q <= left_q - 1'b1;
        end
      end
      if (eng_done_i && pend_q) begin
        pend_q <= 1'b0;
        stp_q  <= stp_q + 1'b1;
        case (st_q)
          SQ_OPEN: if (stp_q == FRAME_END) begin
            st_q  <= SQ_ADDR;
            stp_q <= '0;
          end
          SQ_ADDR: if (stp_q == ADDR_END) begin
            st_q  <= SQ_DATA;
            stp_q <= '0;
          end
          SQ_DATA: begin
            sh_q <= {sh_q[BYTE_BITS-2:0], eng_rbit_i};
            if (stp_q == BYTE_END) begin
              st_q  <= SQ_PUSH;
              stp_q <= '0;
            end
          end
          SQ_CLOSE: if (stp_q == FRAME_END) begin
            st_q  <= SQ_IDLE;
            stp_q <= '0;
          end
          default: stp_q <= stp_q;
        endcase
      end
    end
  end

  AST_REQ_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
  AST_START_ONLY_IDLE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> eng_ready_i); // R6
  AST_NO_CYCLE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_PUSH && !out_free_i) |=> eng_ready_i); // R8
  AST_DONE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done_i |-> pend_q); // R3

endmodule

// File: rtl/smr_beat_reg.sv
module smr_beat_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  output logic         free_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         last_o
);

  logic         valid_q;
  logic [W-1:0] data_q;
  logic         last_q;

  assign free_o = !valid_q || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      last_q  <= last_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q) && $stable(last_q))); // R7

endmodule

// File: rtl/strobe_mem_reader.sv
module strobe_mem_reader
  import smr_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int LOW_CLKS   = 3,
  parameter int REC_CLKS   = 1,
  parameter int LEN_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [BYTE_BITS-1:0] rd_data,
  output logic                 rd_last,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic                 mem_io_o,
  output logic                 mem_io_oe,
  input  logic                 mem_io_i
);

  logic                 eng_ready, eng_done, eng_rbit, eng_start, eng_wbit;
  cyc_kind_e            eng_kind;
  logic                 out_free, push;
  logic [BYTE_BITS-1:0] push_data;
  logic                 push_last;

  smr_seq_ctrl #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_addr_i  (req_addr),
    .req_len_i   (req_len),
    .eng_ready_i (eng_ready),
    .eng_done_i  (eng_done),
    .eng_rbit_i  (eng_rbit),
    .eng_start_o (eng_start),
    .eng_kind_o  (eng_kind),
    .eng_wbit_o  (eng_wbit),
    .out_free_i  (out_free),
    .push_o      (push),
    .push_data_o (push_data),
    .push_last_o (push_last)
  );

  smr_cycle_engine #(
    .SETUP_CLKS (SETUP_CLKS),
    .LOW_CLKS   (LOW_CLKS),
    .REC_CLKS   (REC_CLKS)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .kind_i  (eng_kind),
    .wbit_i  (eng_wbit),
    .ready_o (eng_ready),
    .done_o  (eng_done),
    .rbit_o  (eng_rbit),
    .ce_n_o  (mem_ce_n),
    .oe_n_o  (mem_oe_n),
    .we_n_o  (mem_we_n),
    .io_o    (mem_io_o),
    .io_oe_o (mem_io_oe),
    .io_i    (mem_io_i)
  );

  smr_beat_reg #(.W(BYTE_BITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (push_data),
    .last_i  (push_last),
    .free_o  (out_free),
    .valid_o (rd_valid),
    .ready_i (rd_ready),
    .data_o  (rd_data),
    .last_o  (rd_last)
  );

  AST_LAST_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last && rd_ready) |=> !rd_valid); // R7

endmodule

// File: tb/tb_strobe_mem_reader.sv
module tb_strobe_mem_reader;

  localparam int S = 2;
  localparam int L = 3;
  localparam int RC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        rd_valid, rd_last;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        ce_n, oe_n, we_n, io_o, io_oe, io_i;

  strobe_mem_reader #(.SETUP_CLKS(S), .LOW_CLKS(L), .REC_CLKS(RC), .LEN_W(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_io_o(io_o), .mem_io_oe(io_oe), .mem_io_i(io_i)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done_flag = 1'b0;

  function automatic logic [7:0] memval(int a);
    return 8'(((a & 511) * 37 + ((a & 511) >> 3) + 92) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model
  int          m_abits = 0;
  logic [15:0] m_shift = '0;
  logic [8:0]  m_addr  = '0;
  int          m_bit   = 0;
  int          h1_kind = 0, h1_bit = 0, h2_kind = 0;
  logic [7:0]  cur_byte;
  always_comb cur_byte = memval(int'(m_addr));
  assign io_i = (m_abits == 16) ? cur_byte[7 - m_bit] : 1'b1;

  // bus monitor
  int op_kind[256];
  int op_bit[256];
  int op_w[256];
  int n_ops = 0;
  int lowcnt = 0, gapcnt = 0, min_gap = 1000;
  bit prev_low = 1'b0, we_seen = 1'b0, oe_seen = 1'b0;
  int wbit_seen = 0;
  int viol4 = 0, viol5 = 0, hold_err = 0;
  int beat_data[256];
  int beat_last[256];
  int n_beats = 0;
  bit pv = 1'b0, prdy = 1'b0;
  logic [7:0] pd;
  logic pl;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && !oe_n) viol4++;
      if ((!we_n || !oe_n) && ce_n) viol4++;
      if (!we_n && !io_oe) viol5++;
      if (!oe_n && io_oe) viol5++;
      if (pv && !prdy && !(rd_valid && rd_data == pd && rd_last == pl)) hold_err++;
      pv = rd_valid; prdy = rd_ready; pd = rd_data; pl = rd_last;
      if (rd_valid && rd_ready) begin
        beat_data[n_beats & 255] = int'(rd_data);
        beat_last[n_beats & 255] = int'(rd_last);
        n_beats++;
      end
      if (!ce_n) begin
        if (!prev_low && n_ops > 0 && gapcnt < min_gap) min_gap = gapcnt;
        lowcnt++;
        if (!we_n) begin we_seen = 1'b1; wbit_seen = int'(io_o); end
        if (!oe_n) oe_seen = 1'b1;
        prev_low = 1'b1;
      end else begin
        if (prev_low) begin
          op_kind[n_ops & 255] = we_seen ? 1 : 0;
          op_bit[n_ops & 255]  = we_seen ? wbit_seen : 1;
          op_w[n_ops & 255]    = lowcnt;
          n_ops++;
          if (we_seen) begin
            if (m_abits == 16) m_abits = 0;
            else begin
              m_shift = {m_shift[14:0], 1'(wbit_seen)};
              m_abits++;
              if (m_abits == 16) begin m_addr = m_shift[8:0]; m_bit = 0; end
            end
          end else begin
            if (h1_kind == 1 && h1_bit == 0 && h2_kind == 0) m_abits = 0;
            else if (m_abits == 16) begin
              m_bit++;
              if (m_bit == 8) begin m_bit = 0; m_addr = m_addr + 1'b1; end
            end
          end
          h2_kind = h1_kind;
          h1_kind = we_seen ? 1 : 0;
          h1_bit  = we_seen ? wbit_seen : 1;
          gapcnt = 0;
        end
        gapcnt++;
        lowcnt = 0; we_seen = 1'b0; oe_seen = 1'b0; prev_low = 1'b0;
      end
    end
  end

  task automatic clear_logs();
    n_ops = 0; n_beats = 0; min_gap = 1000;
  endtask

  task automatic send_req(logic [15:0] a, logic [7:0] n);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_len = n;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic wait_done(int nb);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (req_ready && n_beats >= nb) break;
    end
  endtask

  task automatic check_txn(logic [15:0] a, int nb);
    int tot = 22 + 8 * nb;
    bit ok;
    chk(n_ops == tot, "R3 total bus cycles", n_ops, tot);
    ok = (op_kind[0] == 0) && (op_kind[1] == 1) && (op_bit[1] == 0) && (op_kind[2] == 0);
    chk(ok, "R1 opening triple", op_kind[1] * 2 + op_bit[1], 2);
    ok = 1'b1;
    for (int i = 0; i < 16; i++)
      if (op_kind[3 + i] != 1 || op_bit[3 + i] != int'(a[15 - i])) ok = 1'b0;
    chk(ok, "R2 address msb first", int'(a), int'(a));
    ok = 1'b1;
    for (int i = 19; i < 19 + 8 * nb; i++) if (op_kind[i] != 0) ok = 1'b0;
    chk(ok, "R3 byte cycles are reads", 0, 0);
    ok = (op_kind[tot - 3] == 0) && (op_kind[tot - 2] == 1) && (op_bit[tot - 2] == 0) &&
         (op_kind[tot - 1] == 0);
    chk(ok && req_ready, "R9 closing triple then ready", op_kind[tot - 2], 1);
    chk(n_beats == nb, "R7 beat count", n_beats, nb);
    for (int k = 0; k < nb; k++) begin
      int e = int'(memval(int'(a[8:0]) + k));
      chk(beat_data[k] == e && beat_last[k] == ((k == nb - 1) ? 1 : 0),
          "R7 beat data/last", beat_data[k] * 2 + beat_last[k], e * 2 + ((k == nb - 1) ? 1 : 0));
    end
    ok = 1'b1;
    for (int i = 0; i < tot; i++) if (op_w[i] != L) ok = 1'b0;
    chk(ok, "R6 strobe low width", op_w[0], L);
    chk(min_gap >= S + RC, "R6 gap between cycles", min_gap, S + RC);
  endtask

  initial begin : main
    logic [15:0] addrs[4];
    addrs[0] = 16'h0000; addrs[1] = 16'h01FE; addrs[2] = 16'h0155; addrs[3] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(ce_n && oe_n && we_n && !io_oe && !rd_valid, "R5 reset outputs",
        int'({ce_n, oe_n, we_n, io_oe, rd_valid}), 5'b11100);

    for (int ai = 0; ai < 4; ai++) begin
      for (int len = 0; len < 5; len++) begin
        if (len == 3) continue;
        clear_logs();
        send_req(addrs[ai], 8'(len));
        wait_done(len + 1);
        check_txn(addrs[ai], len + 1);
      end
    end

    // back-pressure: three bytes across the wrap, consumer stalled
    clear_logs();
    rd_ready = 1'b0;
    send_req(16'h01FF, 8'd2);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rd_valid) break;
    end
    repeat (150) @(negedge clk);
    chk(n_ops == 35, "R8 bus halted under back-pressure", n_ops, 35);
    chk(rd_valid && rd_data == memval(16'h01FF) && !rd_last, "R7 held beat",
        int'(rd_data), int'(memval(16'h01FF)));
    chk(n_beats == 0 && req_ready == 1'b0, "R8 nothing accepted yet", n_beats, 0);
    @(posedge clk); #1;
    rd_ready = 1'b1;
    wait_done(3);
    check_txn(16'h01FF, 3);
    chk(hold_err == 0, "R7 stability under stall", hold_err, 0);

    chk(viol4 == 0, "R4 strobe overlap", viol4, 0);
    chk(viol5 == 0, "R5 data line drive", viol5, 0);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    wait (cyc >= 150000);
    if (!done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule